// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits beside the two bus ports of a bus-to-bus bridge and decides, for every address phase seen on either side, whether the bridge should claim the transaction and carry it across. A phase arriving on the primary side is claimed when it hits one of the configured downstream windows: an I/O window, a memory window or a prefetchable memory window. The legacy display ranges can be added to these when enabled. A phase arriving on the secondary side is decoded inversely: everything outside the downstream windows is claimed and sent upstream.

Two special cases change the plain window decision. A palette-register write on the primary side can be snooped: it is forwarded while the original target still completes it, so it is flagged without being claimed. A memory region marked opaque is never claimed in either direction. Addresses are 64 bits wide. A dual address cycle carries the low half in a first phase and the high half, with the real command, in a second phase.

Each decision is registered and presented for one clock with a direction flag. Data movement, buffering and bus signalling are handled elsewhere.

Top module: `bridge_window_decoder`

## Requirements
- R1: A write with `cfg_we` high loads the register chosen by `cfg_sel`, and the new value is used from the next clock. The selectable registers are:
  - 0: I/O base, `cfg_wdata[19:0]` = address bits 31:12.
  - 1: I/O limit, same field as the I/O base.
  - 2: memory base, `cfg_wdata[11:0]` = address bits 31:20.
  - 3: memory limit, same field as the memory base.
  - 4: prefetchable base, low part: `cfg_wdata[11:0]` = bits 31:20.
  - 5: prefetchable base, high part: `cfg_wdata` = bits 63:32.
  - 6: prefetchable limit, low part, laid out as select 4.
  - 7: prefetchable limit, high part, laid out as select 5.
  - 8: control: bit0 enables the display ranges, bit1 enables palette snoop, bit2 enables the opaque region.
  - 9: opaque base, laid out as select 2.
  - 10: opaque limit, laid out as select 2.
  - Reset sets every base field to all ones and every limit and control field to zero.
- R2: A window spans from its base with the low address bits zero to its limit with the low bits all ones. The low bits are 12 for I/O and 20 for the memory, prefetchable and opaque windows. Both end addresses are inside the window.
- R3: A window whose limit is below its base matches nothing.
- R4: `claim_valid` is high for exactly one clock, the clock after the final address phase. While it is low, `claim`, `snoop` and `dir_up` are low. While it is high, `dir_up` equals the side that the phase arrived on (1 = secondary).
- R5: On the primary side, an I/O command is claimed inside the I/O window. A memory command is claimed inside the memory window or the prefetchable window.
- R6: On the secondary side, an I/O command is claimed outside the I/O window. A memory command is claimed outside both memory windows. When the display ranges are enabled, those ranges also count as downstream space.
- R7: With the display ranges enabled, the following are claimed on the primary side: memory 0xA0000–0xBFFFF, and I/O 0x3B0–0x3BB and 0x3C0–0x3DF.
- R8: With palette snoop enabled, a primary-side I/O write (command 0011) to 0x3C6, 0x3C8 or 0x3C9 that is not otherwise claimed gives `snoop`=1 and `claim`=0. Reads and other addresses do not snoop.
- R9: Command 1101 in a phase marks a dual address cycle. That phase carries address bits 31:0 and produces no decision. The next phase carries bits 63:32 and the real command, and is decided on the side of the first phase. A single-phase address has bits 63:32 zero.
- R10: With the opaque region enabled, a memory command inside it is never claimed on either side.
- R11: I/O commands are 0010 and 0011. Memory commands are 0110, 0111, 1100, 1110 and 1111. Any other command, such as configuration (1010/1011) or special cycle (0001), never gives `claim` or `snoop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_valid | input | 1 | Address phase strobe |
| phase_addr | input | 32 | Address bits of this phase |
| phase_cmd | input | 4 | Bus command of this phase |
| from_secondary | input | 1 | Phase seen on the secondary side |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| claim_valid | output | 1 | Decision strobe |
| claim | output | 1 | Claim and forward |
| snoop | output | 1 | Forward without claiming |
| dir_up | output | 1 | Forward direction is upstream |

## Verification
A register write and an address decision can fall in the same clock. In that case the decision must use the window as it stood before the write, and the new value applies only from the next phase. The bench provokes this by asserting a phase and a write that moves the matching window in the same cycle, then repeating the phase, and judges both results against its reference model. The display ranges and palette snoop can also both apply to one address. The bench runs palette writes with snoop alone and with the display ranges on, and expects a snoop in the first case and a plain claim in the second.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int AW     = 64;
  localparam int HW     = 32;
  localparam int IO_SH  = 12;
  localparam int MEM_SH = 20;
  localparam int IO_FW  = HW - IO_SH;
  localparam int MEM_FW = HW - MEM_SH;
  localparam int PF_FW  = AW - MEM_SH;
  localparam int SEL_W  = 4;

  localparam logic [3:0] CMD_SPECIAL = 4'b0001;
  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_DUAL    = 4'b1101;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  typedef struct packed {
    logic [IO_FW-1:0]  io_base;
    logic [IO_FW-1:0]  io_limit;
    logic [MEM_FW-1:0] mem_base;
    logic [MEM_FW-1:0] mem_limit;
    logic [PF_FW-1:0]  pf_base;
    logic [PF_FW-1:0]  pf_limit;
    logic [MEM_FW-1:0] opq_base;
    logic [MEM_FW-1:0] opq_limit;
    logic              vga_en;
    logic              pal_en;
    logic              opq_en;
  } win_cfg_t;

  // key within [base, limit]; an inverted pair matches nothing
  function automatic logic span_hit(input logic [PF_FW-1:0] key,
                                    input logic [PF_FW-1:0] base,
                                    input logic [PF_FW-1:0] limit);
    return (base <= limit) && (key >= base) && (key <= limit);
  endfunction

  function automatic logic in_range(input logic [HW-1:0] a,
                                    input logic [HW-1:0] lo,
                                    input logic [HW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic is_io_cmd(input logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR);
  endfunction

  function automatic logic is_mem_cmd(input logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_MEM_RDM) ||
           (c == CMD_MEM_RDL) || (c == CMD_MEM_WRI);
  endfunction
endpackage

// File: rtl/bwd_cfg_regs.sv
module bwd_cfg_regs
  import bwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [HW-1:0]    wdata,
  output win_cfg_t         cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.io_base   <= '1;
      cfg.io_limit  <= '0;
      cfg.mem_base  <= '1;
      cfg.mem_limit <= '0;
      cfg.pf_base   <= '1;
      cfg.pf_limit  <= '0;
      cfg.opq_base  <= '1;
      cfg.opq_limit <= '0;
      cfg.vga_en    <= 1'b0;
      cfg.pal_en    <= 1'b0;
      cfg.opq_en    <= 1'b0;
    end else if (we) begin
      case (sel)
        4'd0:  cfg.io_base   <= wdata[IO_FW-1:0];
        4'd1:  cfg.io_limit  <= wdata[IO_FW-1:0];
        4'd2:  cfg.mem_base  <= wdata[MEM_FW-1:0];
        4'd3:  cfg.mem_limit <= wdata[MEM_FW-1:0];
        4'd4:  cfg.pf_base[MEM_FW-1:0]      <= wdata[MEM_FW-1:0];
        4'd5:  cfg.pf_base[PF_FW-1:MEM_FW]  <= wdata;
        4'd6:  cfg.pf_limit[MEM_FW-1:0]     <= wdata[MEM_FW-1:0];
        4'd7:  cfg.pf_limit[PF_FW-1:MEM_FW] <= wdata;
        4'd8:  begin
          cfg.vga_en <= wdata[0];
          cfg.pal_en <= wdata[1];
          cfg.opq_en <= wdata[2];
        end
        4'd9:  cfg.opq_base  <= wdata[MEM_FW-1:0];
        4'd10: cfg.opq_limit <= wdata[MEM_FW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bwd_phase_capture.sv
module bwd_phase_capture
  import bwd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [HW-1:0] addr,
  input  logic [3:0]    cmd,
  input  logic          side,
  output logic          dac_first,
  output logic          decide,
  output logic [AW-1:0] full_addr,
  output logic          eff_side
);
  logic          pend_q;
  logic [HW-1:0] lo_q;
  logic          side_q;

  assign dac_first = valid && !pend_q && (cmd == CMD_DUAL);
  assign decide    = valid && !dac_first;
  assign full_addr = pend_q ? {addr, lo_q} : {{(AW-HW){1'b0}}, addr};
  assign eff_side  = pend_q ? side_q : side;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
      side_q <= 1'b0;
    end else if (dac_first) begin
      pend_q <= 1'b1;
      lo_q   <= addr;
      side_q <= side;
    end else if (decide) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bwd_match.sv
module bwd_match
  import bwd_pkg::*;
(
  input  win_cfg_t      cfg,
  input  logic [AW-1:0] a,
  input  logic [3:0]    cmd,
  input  logic          up,
  output logic          cmd_io,
  output logic          cmd_mem,
  output logic          opq_mem,
  output logic          claim,
  output logic          snoop
);
  logic          hi_zero;
  logic [HW-1:0] lo;
  logic io_hit, mem_hit, pf_hit, opq_hit, vga_io, vga_mem, pal_hit;
  logic dn_space, fwd;

  assign lo      = a[HW-1:0];
  assign hi_zero = (a[AW-1:HW] == '0);
  assign cmd_io  = is_io_cmd(cmd);
  assign cmd_mem = is_mem_cmd(cmd);

  assign io_hit  = hi_zero && span_hit(PF_FW'(a[HW-1:IO_SH]),
                                       PF_FW'(cfg.io_base), PF_FW'(cfg.io_limit));
  assign mem_hit = hi_zero && span_hit(PF_FW'(a[HW-1:MEM_SH]),
                                       PF_FW'(cfg.mem_base), PF_FW'(cfg.mem_limit));
  assign pf_hit  = span_hit(a[AW-1:MEM_SH], cfg.pf_base, cfg.pf_limit);
  assign opq_hit = cfg.opq_en && hi_zero &&
                   span_hit(PF_FW'(a[HW-1:MEM_SH]),
                            PF_FW'(cfg.opq_base), PF_FW'(cfg.opq_limit));

  assign vga_io  = cfg.vga_en && hi_zero &&
                   (in_range(lo, 32'h3B0, 32'h3BB) || in_range(lo, 32'h3C0, 32'h3DF));
  assign vga_mem = cfg.vga_en && hi_zero && in_range(lo, 32'hA0000, 32'hBFFFF);
  assign pal_hit = cfg.pal_en && hi_zero && (cmd == CMD_IO_WR) &&
                   ((lo == 32'h3C6) || (lo == 32'h3C8) || (lo == 32'h3C9));

  assign dn_space = cmd_io ? (io_hit || vga_io) : (mem_hit || pf_hit || vga_mem);
  assign fwd      = (cmd_io || cmd_mem) && (up ? !dn_space : dn_space);
  assign opq_mem  = cmd_mem && opq_hit;
  assign claim    = fwd && !opq_mem;
  assign snoop    = !up && pal_hit && !claim;
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_valid,
  input  logic [HW-1:0]    phase_addr,
  input  logic [3:0]       phase_cmd,
  input  logic             from_secondary,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [HW-1:0]    cfg_wdata,
  output logic             claim_valid,
  output logic             claim,
  output logic             snoop,
  output logic             dir_up
);
  win_cfg_t      cfg;
  logic          dac_first, decide, eff_side;
  logic [AW-1:0] full_addr;
  logic          cmd_io, cmd_mem, opq_mem, nxt_claim, nxt_snoop;

  bwd_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  bwd_phase_capture u_cap (
    .clk(clk), .rst_n(rst_n), .valid(phase_valid), .addr(phase_addr),
    .cmd(phase_cmd), .side(from_secondary), .dac_first(dac_first),
    .decide(decide), .full_addr(full_addr), .eff_side(eff_side)
  );

  bwd_match u_match (
    .cfg(cfg), .a(full_addr), .cmd(phase_cmd), .up(eff_side),
    .cmd_io(cmd_io), .cmd_mem(cmd_mem), .opq_mem(opq_mem),
    .claim(nxt_claim), .snoop(nxt_snoop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_valid <= 1'b0;
      claim       <= 1'b0;
      snoop       <= 1'b0;
      dir_up      <= 1'b0;
    end else begin
      claim_valid <= decide;
      claim       <= decide && nxt_claim;
      snoop       <= decide && nxt_snoop;
      dir_up      <= decide && eff_side;
    end
  end
endmodule

module bwd_checker (
  input logic clk,
  input logic rst_n,
  input logic decide,
  input logic dac_first,
  input logic eff_side,
  input logic cmd_io,
  input logic cmd_mem,
  input logic opq_mem,
  input logic claim_valid,
  input logic claim,
  input logic snoop,
  input logic dir_up
);
  assert_decide_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> claim_valid);
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> !claim_valid);
  assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_valid |-> (!claim && !snoop && !dir_up));
  assert_dir_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    claim_valid |-> (dir_up == $past(eff_side)));
  assert_dac_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dac_first |=> !claim_valid);
  assert_opaque_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && opq_mem) |=> !claim);
  assert_snoop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snoop |-> (!claim && !dir_up));
  assert_cmd_filter_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !cmd_io && !cmd_mem) |=> (!claim && !snoop));
endmodule

bind bridge_window_decoder bwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .decide(decide), .dac_first(dac_first),
  .eff_side(eff_side), .cmd_io(cmd_io), .cmd_mem(cmd_mem), .opq_mem(opq_mem),
  .claim_valid(claim_valid), .claim(claim), .snoop(snoop), .dir_up(dir_up)
);

// File: tb/bridge_window_decoder_test.sv
module bridge_window_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_valid = 1'b0;
  logic [31:0] phase_addr = '0;
  logic [3:0]  phase_cmd = '0;
  logic        from_secondary = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        claim_valid, claim, snoop, dir_up;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .phase_valid(phase_valid), .phase_addr(phase_addr),
    .phase_cmd(phase_cmd), .from_secondary(from_secondary), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .claim_valid(claim_valid),
    .claim(claim), .snoop(snoop), .dir_up(dir_up)
  );

  // ---------------- reference model ----------------
  logic [19:0] m_iob, m_iol;
  logic [11:0] m_mb, m_ml, m_ob, m_ol;
  logic [43:0] m_pb, m_pl;
  logic m_vga, m_pal, m_opq;
  logic m_pend, m_pside;
  logic [31:0] m_lo;
  logic e_v, e_c, e_s, e_d;

  function automatic logic inside_win(input logic [63:0] a, input logic [63:0] lo,
                                      input logic [63:0] hi);
    return lo <= hi && a >= lo && a <= hi;
  endfunction

  task automatic judge(input logic [63:0] a, input logic [3:0] c, input logic up,
                       output logic cl, output logic sn);
    logic isio, ismem, w_io, w_mem, w_pf, v_io, v_mem, op, pal, dn;
    isio  = (c == 4'h2) || (c == 4'h3);
    ismem = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
    w_io  = inside_win(a, 64'(m_iob) * 64'h1000, 64'(m_iol) * 64'h1000 + 64'hFFF);
    w_mem = inside_win(a, 64'(m_mb) * 64'h100000, 64'(m_ml) * 64'h100000 + 64'hFFFFF);
    w_pf  = inside_win(a, 64'(m_pb) * 64'h100000, 64'(m_pl) * 64'h100000 + 64'hFFFFF);
    op    = m_opq && inside_win(a, 64'(m_ob) * 64'h100000, 64'(m_ol) * 64'h100000 + 64'hFFFFF);
    v_io  = m_vga && ((a >= 64'h3B0 && a <= 64'h3BB) || (a >= 64'h3C0 && a <= 64'h3DF));
    v_mem = m_vga && a >= 64'hA0000 && a <= 64'hBFFFF;
    pal   = m_pal && c == 4'h3 && (a == 64'h3C6 || a == 64'h3C8 || a == 64'h3C9);
    dn    = isio ? (w_io || v_io) : (w_mem || w_pf || v_mem);
    cl    = (isio || ismem) && (up ? !dn : dn) && !(ismem && op);
    sn    = !up && pal && !cl;
  endtask

  always @(posedge clk) begin
    logic cl, sn;
    if (!rst_n) begin
      m_iob = '1; m_iol = '0; m_mb = '1; m_ml = '0; m_pb = '1; m_pl = '0;
      m_ob = '1; m_ol = '0; m_vga = 0; m_pal = 0; m_opq = 0;
      m_pend = 0; m_pside = 0; m_lo = '0;
      e_v = 0; e_c = 0; e_s = 0; e_d = 0;
    end else begin
      e_v = 0; e_c = 0; e_s = 0; e_d = 0;
      if (phase_valid) begin
        if (m_pend) begin
          judge({phase_addr, m_lo}, phase_cmd, m_pside, cl, sn);
          e_v = 1; e_c = cl; e_s = sn; e_d = m_pside; m_pend = 0;
        end else if (phase_cmd == 4'hD) begin
          m_pend = 1; m_lo = phase_addr; m_pside = from_secondary;
        end else begin
          judge({32'h0, phase_addr}, phase_cmd, from_secondary, cl, sn);
          e_v = 1; e_c = cl; e_s = sn; e_d = from_secondary;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          4'd0: m_iob = cfg_wdata[19:0];
          4'd1: m_iol = cfg_wdata[19:0];
          4'd2: m_mb = cfg_wdata[11:0];
          4'd3: m_ml = cfg_wdata[11:0];
          4'd4: m_pb[11:0] = cfg_wdata[11:0];
          4'd5: m_pb[43:12] = cfg_wdata;
          4'd6: m_pl[11:0] = cfg_wdata[11:0];
          4'd7: m_pl[43:12] = cfg_wdata;
          4'd8: begin m_vga = cfg_wdata[0]; m_pal = cfg_wdata[1]; m_opq = cfg_wdata[2]; end
          4'd9: m_ob = cfg_wdata[11:0];
          4'd10: m_ol = cfg_wdata[11:0];
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({claim_valid, claim, snoop, dir_up} !== {e_v, e_c, e_s, e_d}) begin
        errors++;
        $display("FAIL %s: {valid,claim,snoop,up} actual=%b%b%b%b expected=%b%b%b%b",
                 tag, claim_valid, claim, snoop, dir_up, e_v, e_c, e_s, e_d);
      end
    end
  end

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ph(input logic [31:0] a, input logic [3:0] c, input logic side);
    @(negedge clk);
    phase_valid = 1; phase_addr = a; phase_cmd = c; from_secondary = side;
    @(negedge clk);
    phase_valid = 0;
    @(negedge clk);
  endtask

  task automatic dual(input logic [31:0] lo, input logic [31:0] hi,
                      input logic [3:0] c, input logic side);
    @(negedge clk);
    phase_valid = 1; phase_addr = lo; phase_cmd = 4'hD; from_secondary = side;
    @(negedge clk);
    phase_addr = hi; phase_cmd = c; from_secondary = !side;
    @(negedge clk);
    phase_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state with all windows disabled
    checks++;
    if ({claim_valid, claim, snoop, dir_up} !== 4'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual=%b%b%b%b expected=0000",
               claim_valid, claim, snoop, dir_up);
    end
    rst_n = 1;
    tag = "R1"; ph(32'h8000_0000, 4'h6, 0); ph(32'h8000_0000, 4'h6, 1);
    tag = "R4"; ph(32'h0000_1000, 4'h2, 1);

    // R2 R5 R6: I/O window 0x10000-0x1FFFF
    tag = "R1"; wr(0, 32'h10); wr(1, 32'h1F);
    tag = "R2"; ph(32'h0001_0000, 4'h2, 0); ph(32'h0001_FFFF, 4'h3, 0);
    ph(32'h0002_0000, 4'h2, 0); ph(32'h0000_FFFF, 4'h2, 0);
    tag = "R6"; ph(32'h0002_0000, 4'h2, 1); ph(32'h0001_0000, 4'h3, 1);

    // memory window 0x80000000-0x80FFFFFF
    tag = "R5"; wr(2, 32'h800); wr(3, 32'h80F);
    ph(32'h80FF_FFFF, 4'h7, 0); ph(32'h8100_0000, 4'h6, 0); ph(32'h8000_0000, 4'hC, 0);
    tag = "R6"; ph(32'h8100_0000, 4'hE, 1); ph(32'h8080_0000, 4'hF, 1);

    // R9: prefetchable window above 4 GiB via dual address cycles
    tag = "R9"; wr(4, 32'h0); wr(5, 32'h1); wr(6, 32'hFFF); wr(7, 32'h1);
    dual(32'h0000_1000, 32'h1, 4'h6, 0); dual(32'hFFFF_FFFF, 32'h1, 4'h7, 0);
    dual(32'h0000_1000, 32'h2, 4'h6, 0); dual(32'h0000_1000, 32'h2, 4'h6, 1);
    dual(32'h0000_1000, 32'h1, 4'h6, 1);

    // R3: limit below base disables
    tag = "R3"; wr(1, 32'hF);
    ph(32'h0001_0000, 4'h2, 0); ph(32'h0001_0000, 4'h2, 1);
    wr(1, 32'h1F);

    // R7: display ranges
    tag = "R7"; wr(8, 32'h1);
    ph(32'h000A_0000, 4'h6, 0); ph(32'h000B_FFFF, 4'h7, 0); ph(32'h000C_0000, 4'h6, 0);
    ph(32'h0000_03B0, 4'h2, 0); ph(32'h0000_03DF, 4'h3, 0); ph(32'h0000_03BC, 4'h2, 0);
    tag = "R6"; ph(32'h000A_0000, 4'h6, 1); ph(32'h0000_03C4, 4'h2, 1);

    // R8: palette snoop alone, then together with display ranges
    tag = "R8"; wr(8, 32'h2);
    ph(32'h0000_03C6, 4'h3, 0); ph(32'h0000_03C9, 4'h3, 0); ph(32'h0000_03C6, 4'h2, 0);
    ph(32'h0000_03C7, 4'h3, 0); ph(32'h0000_03C8, 4'h3, 1);
    wr(8, 32'h3); ph(32'h0000_03C8, 4'h3, 0);

    // R10: opaque region on both sides
    tag = "R10"; wr(9, 32'h800); wr(10, 32'h800); wr(8, 32'h4);
    ph(32'h8000_0000, 4'h6, 0); ph(32'h8010_0000, 4'h6, 0);
    wr(9, 32'h900); wr(10, 32'h900);
    ph(32'h9000_0000, 4'h7, 1); ph(32'h9010_0000, 4'h7, 1);
    wr(8, 32'h0); ph(32'h9000_0000, 4'h7, 1);

    // R11: command filter
    tag = "R11";
    ph(32'h8000_0000, 4'hA, 0); ph(32'h8000_0000, 4'hB, 1); ph(32'h0001_0000, 4'h1, 0);
    ph(32'h0001_0000, 4'h0, 1); ph(32'h8000_0000, 4'h4, 0);

    // R1 R4: write and decision in one clock; back-to-back phases
    tag = "R1";
    @(negedge clk);
    phase_valid = 1; phase_addr = 32'h8000_0000; phase_cmd = 4'h6; from_secondary = 0;
    cfg_we = 1; cfg_sel = 4'd2; cfg_wdata = 32'h900;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    phase_valid = 0;
    tag = "R4";
    @(negedge clk);
    phase_valid = 1; phase_addr = 32'h0001_2000; phase_cmd = 4'h2; from_secondary = 0;
    @(negedge clk);
    from_secondary = 1;
    @(negedge clk);
    phase_cmd = 4'hD;
    @(negedge clk);
    phase_addr = 32'h0; phase_cmd = 4'h6;
    @(negedge clk);
    phase_valid = 0;
    repeat (3) @(negedge clk);

    done = 1;
    report();
    $finish;
  end
endmodule